// File: doc/BRIEF.md
# Controller Operating-State Transition Manager

This block moves a memory controller into a requested operating state. The controller has three states of interest: low-power, access and config. A request asks for either config or access. The block reads the controller's current state from a masked field of its status word and picks one step. It issues that step as an encoded command with a one-cycle strobe. It then waits until the status shows the state the step leads to, and reads the status again. When the status matches the target, it pulses `done` and accepts the next request.

The request side is a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` stays low from that edge until the cycle in which `done` pulses, so the requester sees back-pressure for the whole transition. A request offered while the block is busy is neither taken nor remembered. The status input and the command outputs are plain pins.

Top module: `opstate_mover`

## Requirements
- R1: After reset, `req_ready` is 1, and `done` and `cmd_strobe` are 0.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high on a rising edge. `req_ready` is 0 from the accepting edge until `done` pulses. A `req_valid` offered while the block is busy has no effect on the target being pursued.
- R3: If the status already shows the target state, no command is issued. `done` is high during the second cycle after the accepting edge, for exactly one cycle.
- R4: Reaching config from access issues exactly one config command (code 2'b10), then waits for config. `done` and `cmd_strobe` are never high together.
- R5: Reaching access from config issues exactly one go command (code 2'b11), then waits for access.
- R6: Reaching access from low-power issues exactly one wakeup command (code 2'b01), then waits for access. A wakeup is issued only when the status showed low-power.
- R7: Reaching config from low-power issues wakeup, waits for access, then issues config and waits for config. That is two commands in the order 2'b01 then 2'b10.
- R8: `cmd_strobe` is high for single cycles only. No command is issued while the block is waiting for the status to reach the expected state.
- R9: Only status bits [FIELD_LSB+2:FIELD_LSB] are decoded, and FIELD_LSB is 0 by default. In that field, low-power is 3'b101, access is 3'b011 and config is 3'b001. Changes to all other status bits do not affect the commands or `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Transition request offered |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_to_config | input | 1 | Target of the request: 1 = config, 0 = access |
| ctl_status | input | STAT_W | Controller status word; the state field sits at FIELD_LSB |
| cmd_strobe | output | 1 | One-cycle pulse marking a valid command |
| cmd_code | output | 2 | Command: 01 wakeup, 10 config, 11 go |
| done | output | 1 | One-cycle pulse when the target state is reached |

## Verification
The assertions check, on every cycle, the following: the strobe is single-cycle; no strobe appears while the block is waiting for a state change; a wakeup follows only from a low-power reading; `done` never coincides with a command and appears only after the status matched the target; and `req_ready` drops after an accepted request. Only the bench's scenarios can show the rest. These are the full command order for each start/target pair, the exact cycle of `done` when no command is needed, and the fact that junk in the undecoded status bits or a request made while busy changes nothing. For these checks a controller model answers each command after a random latency.

// File: rtl/opstate_pkg.sv
package opstate_pkg;
  localparam int FIELD_W = 3;
  typedef logic [FIELD_W-1:0] ctl_state_t;
  localparam ctl_state_t ST_LOWPWR = 3'b101;
  localparam ctl_state_t ST_ACCESS = 3'b011;
  localparam ctl_state_t ST_CONFIG = 3'b001;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_WAKE = 2'b01,
    CMD_CFG  = 2'b10,
    CMD_GO   = 2'b11
  } cmd_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DECIDE = 2'd1,
    PH_WAIT   = 2'd2
  } phase_t;
endpackage

// File: rtl/opstate_field.sv
module opstate_field
  import opstate_pkg::*;
#(
  parameter int STAT_W    = 8,
  parameter int FIELD_LSB = 0
) (
  input  logic [STAT_W-1:0] status,
  output ctl_state_t        cur
);
  localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

  initial begin
    if (FIELD_MSB >= STAT_W) $error("state field does not fit in status word");
  end

  assign cur = status[FIELD_MSB:FIELD_LSB];
endmodule

// File: rtl/opstate_planner.sv
module opstate_planner
  import opstate_pkg::*;
(
  input  ctl_state_t cur,
  input  logic       to_config,
  output logic       at_target,
  output logic       step_ok,
  output cmd_t       step_cmd,
  output ctl_state_t step_expect
);
  ctl_state_t goal;

  always_comb begin
    goal        = to_config ? ST_CONFIG : ST_ACCESS;
    at_target   = (cur == goal);
    step_ok     = 1'b0;
    step_cmd    = CMD_NONE;
    step_expect = cur;
    if (!at_target) begin
      if (cur == ST_LOWPWR) begin
        // low-power always leaves through access
        step_ok     = 1'b1;
        step_cmd    = CMD_WAKE;
        step_expect = ST_ACCESS;
      end else if (cur == ST_ACCESS && to_config) begin
        step_ok     = 1'b1;
        step_cmd    = CMD_CFG;
        step_expect = ST_CONFIG;
      end else if (cur == ST_CONFIG && !to_config) begin
        step_ok     = 1'b1;
        step_cmd    = CMD_GO;
        step_expect = ST_ACCESS;
      end
    end
  end
endmodule

// File: rtl/opstate_mover.sv
module opstate_mover
  import opstate_pkg::*;
#(
  parameter int STAT_W    = 8,
  parameter int FIELD_LSB = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_to_config,
  input  logic [STAT_W-1:0] ctl_status,
  output logic              cmd_strobe,
  output logic [1:0]        cmd_code,
  output logic              done
);
  phase_t     phase_q;
  logic       to_cfg_q;
  ctl_state_t expect_q;
  ctl_state_t cur;
  logic       at_target, step_ok;
  cmd_t       step_cmd;
  ctl_state_t step_expect;
  cmd_t       code_q;

  opstate_field #(.STAT_W(STAT_W), .FIELD_LSB(FIELD_LSB)) u_field (
    .status(ctl_status),
    .cur   (cur)
  );

  opstate_planner u_plan (
    .cur        (cur),
    .to_config  (to_cfg_q),
    .at_target  (at_target),
    .step_ok    (step_ok),
    .step_cmd   (step_cmd),
    .step_expect(step_expect)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      to_cfg_q   <= 1'b0;
      expect_q   <= ST_ACCESS;
      cmd_strobe <= 1'b0;
      code_q     <= CMD_NONE;
      done       <= 1'b0;
    end else begin
      cmd_strobe <= 1'b0;
      done       <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (req_valid) begin
            to_cfg_q <= req_to_config;
            phase_q  <= PH_DECIDE;
          end
        end
        PH_DECIDE: begin
          if (at_target) begin
            done    <= 1'b1;
            phase_q <= PH_IDLE;
          end else if (step_ok) begin
            cmd_strobe <= 1'b1;
            code_q     <= step_cmd;
            expect_q   <= step_expect;
            phase_q    <= PH_WAIT;
          end
        end
        PH_WAIT: begin
          if (cur == expect_q) phase_q <= PH_DECIDE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign req_ready = (phase_q == PH_IDLE);
  assign cmd_code  = code_q;

  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_strobe |=> !cmd_strobe);

  p_quiet_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_WAIT && $past(phase_q) == PH_WAIT) |-> !cmd_strobe);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_wake_from_lowpwr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_strobe && cmd_code == CMD_WAKE) |-> $past(cur) == ST_LOWPWR);

  p_done_at_goal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(cur) == (to_cfg_q ? ST_CONFIG : ST_ACCESS));

  p_done_no_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && cmd_strobe));
endmodule

// File: tb/tb_opstate_mover.sv
module tb_opstate_mover;
  localparam int CLK_PERIOD = 10;
  localparam logic [2:0] LP = 3'b101, AC = 3'b011, CF = 3'b001;

  logic       clk = 0, rst_n = 0;
  logic       req_valid = 0, req_to_config = 0;
  logic       req_ready, cmd_strobe, done;
  logic [1:0] cmd_code;
  logic [7:0] ctl_status;

  logic [2:0] st_field = AC;
  logic [4:0] junk = 5'b0;
  logic       pending = 0;
  logic [2:0] next_st;
  int         countdown = 0;
  int         overlap_err = 0;
  logic [1:0] log_q [0:7];
  int         nlog = 0;
  int         total = 0, bad = 0;

  assign ctl_status = {junk, st_field};

  opstate_mover dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_to_config(req_to_config), .ctl_status(ctl_status),
    .cmd_strobe(cmd_strobe), .cmd_code(cmd_code), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // controller model: answers each command after a random latency
  always @(posedge clk) begin
    if (cmd_strobe) begin
      if (pending) overlap_err <= overlap_err + 1;
      if (nlog < 8) log_q[nlog] <= cmd_code;
      nlog      <= nlog + 1;
      pending   <= 1'b1;
      countdown <= int'($urandom_range(1, 6));
      next_st   <= (cmd_code == 2'b10) ? CF : AC;
    end else if (pending) begin
      if (countdown <= 1) begin
        st_field <= next_st;
        pending  <= 1'b0;
      end else countdown <= countdown - 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start(input logic [2:0] st0, input logic to_cfg);
    @(negedge clk);
    st_field = st0;
    nlog = 0;
    overlap_err = 0;
    req_to_config = to_cfg;
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(req, {31'b0, done}, 32'd1);
  endtask

  task automatic run_case(input string req, input logic [2:0] st0, input logic to_cfg,
                          input int exp_n, input logic [1:0] c0, input logic [1:0] c1);
    start(st0, to_cfg);
    chk({req, " ready low while busy"}, {31'b0, req_ready}, 32'd0);
    wait_done(req);
    chk({req, " command count"}, nlog, exp_n);
    if (exp_n > 0) chk({req, " first command"}, log_q[0], c0);
    if (exp_n > 1) chk({req, " second command"}, log_q[1], c1);
    chk({req, " final state"}, st_field, to_cfg ? CF : AC);
    chk({req, " R8 no command while pending"}, overlap_err, 0);
    @(negedge clk);
    chk({req, " done one cycle"}, {31'b0, done}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1 ready", {31'b0, req_ready}, 32'd1);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 strobe", {31'b0, cmd_strobe}, 32'd0);
  endtask

  task automatic t_already_there();
    start(CF, 1'b1);
    chk("R3 not yet done", {31'b0, done}, 32'd0);
    @(negedge clk);
    chk("R3 done in second cycle", {31'b0, done}, 32'd1);
    chk("R3 no command", nlog, 0);
    @(negedge clk);
    chk("R3 done single cycle", {31'b0, done}, 32'd0);
    start(AC, 1'b0);
    @(negedge clk);
    chk("R3 access done", {31'b0, done}, 32'd1);
    chk("R3 access no command", nlog, 0);
  endtask

  task automatic t_busy_req();
    // lowpwr -> config; offer an access request mid-way, which must be ignored
    start(LP, 1'b1);
    req_to_config = 0;
    req_valid = 1;
    repeat (3) @(negedge clk);
    req_valid = 0;
    wait_done("R2 busy request");
    chk("R2 target kept", st_field, CF);
    chk("R2 commands", nlog, 2);
  endtask

  task automatic t_junk_bits();
    junk = 5'b10110;
    run_case("R9 junk bits lp->acc", LP, 1'b0, 1, 2'b01, 2'b00);
    junk = 5'b01001;
    run_case("R9 junk bits acc->cfg", AC, 1'b1, 1, 2'b10, 2'b00);
    junk = 5'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_already_there();
    run_case("R4 acc->cfg", AC, 1'b1, 1, 2'b10, 2'b00);
    run_case("R5 cfg->acc", CF, 1'b0, 1, 2'b11, 2'b00);
    run_case("R6 lp->acc", LP, 1'b0, 1, 2'b01, 2'b00);
    run_case("R7 lp->cfg", LP, 1'b1, 2, 2'b01, 2'b10);
    for (int i = 0; i < 6; i++)
      run_case("R7 lp->cfg repeat", LP, 1'b1, 2, 2'b01, 2'b10);
    t_busy_req();
    t_junk_bits();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule